// File: doc/BRIEF.md
# Eight-bit ALU with flags

This block is the arithmetic and logic stage of a small RISC core. Each accepted operation takes an eight-bit operand `opa`, a second operand `opb` and the carry held in the block's status register. The second operand is either another register or an immediate; the block treats both the same way. It returns a registered result and updates the eight-bit status register. Every operation changes only the flags that belong to it. The other flags keep their values, which lets software chain multi-byte arithmetic and compares.

Two operations add or subtract a six-bit immediate (`opb[5:0]`) to or from a sixteen-bit register pair on `pair_in`. They take two clocks: the low byte is computed in the first cycle and the high byte with the carry in the second. While `busy` is high the block accepts no new operation. Flag set and flag clear operations pick one status bit by the index in `opb[2:0]`. The register file, decode and fetch sit outside the block.

Top module: `alu8_core`

## Requirements
- R1: After synchronous reset the status flags are all 0, and `res_valid`, `res_write` and `busy` are 0.
- R2: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Add, add-with-carry, subtract and subtract-with-carry write an eight-bit result and update C, Z, N, V, H and S. The carry forms also add or subtract the stored C. H is the carry out of bit 3, or the borrow into it. S equals N XOR V.
- R3: Subtract-with-carry and compare-with-carry clear Z when the result is nonzero. When the result is zero, Z keeps its previous value.
- R4: Compare and compare-with-carry update flags exactly like the matching subtracts and raise no `res_write`.
- R5: AND, OR, XOR, mask-clear (opa AND NOT opb), test and clear-register update only Z, N, V and S, with V forced to 0. Increment and decrement update only Z, N, V and S. Their V is set on signed overflow.
- R6: Ones' complement returns 0xFF minus opa and sets C, with V at 0. Negate returns 0x00 minus opa and updates C, Z, N, V, H and S as a subtract from zero.
- R7: Nibble swap exchanges opa[7:4] and opa[3:0] and leaves every flag unchanged.
- R8: Arithmetic shift right keeps bit 7, logical shift right fills bit 7 with 0 and logical shift left fills bit 0 with 0. Each shift updates C with the bit shifted out, and also updates Z, N and S. V becomes N XOR C, and H is left unchanged.
- R9: Rotate left moves the old C into bit 0 and bit 7 into C. Rotate right moves the old C into bit 7 and bit 0 into C. The other flags follow the rule of R8.
- R10: A word add or word subtract of `opb[5:0]` on `pair_in` raises `busy` for one cycle. It then delivers the sixteen-bit result with Z, C, N, V and S updated. An operation offered while `busy` is high is ignored.
- R11: Flag set and flag clear force the status bit indexed by `opb[2:0]` to 1 or to 0 and raise no `res_write`.
- R12: I and T change only through flag set or flag clear.
- R13: Every accepted one-cycle operation raises `res_valid` for exactly the next cycle. `res_write` is low for compares and flag operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_code | input | 5 | Operation encoding from the package enum |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand, immediate, word immediate or flag index |
| pair_in | input | 16 | Register pair for word operations |
| res_valid | output | 1 | Result and flags of an operation are available |
| res_write | output | 1 | Result should be written back |
| res_data | output | 16 | Result, zero-extended for eight-bit operations |
| flags | output | 8 | Status register |
| busy | output | 1 | Second cycle of a word operation; inputs ignored |

## Verification
The assertions assume that `op_code` carries one of the package encodings. They also assume that an operation is accepted exactly when `op_valid` is high and `busy` is low. The stimulus therefore drives only enum values, and it offers a second operation during `busy` only in the case that tests its rejection. Status flags are never initialised by the bench beyond reset. Each sweep starts from whatever flags the previous operation left, so both values of the sticky zero and the stored carry come up across the sweeps.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW    = 8;
    localparam int WW    = 2 * DW;
    localparam int IMMW  = 6;
    localparam int FLW   = 8;
    localparam int FIDXW = $clog2(FLW);
    localparam int OPW   = 5;
    localparam int MSB   = DW - 1;
    localparam int HB    = DW / 2 - 1;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,  OP_CPC  = 5'd5,  OP_INC  = 5'd6,  OP_DEC  = 5'd7,
        OP_NEG  = 5'd8,  OP_AND  = 5'd9,  OP_OR   = 5'd10, OP_XOR  = 5'd11,
        OP_CLRM = 5'd12, OP_TST  = 5'd13, OP_CLR  = 5'd14, OP_COM  = 5'd15,
        OP_SWAP = 5'd16, OP_ASR  = 5'd17, OP_LSR  = 5'd18, OP_LSL  = 5'd19,
        OP_ROL  = 5'd20, OP_ROR  = 5'd21, OP_WADD = 5'd22, OP_WSUB = 5'd23,
        OP_FSET = 5'd24, OP_FCLR = 5'd25
    } alu_op_e;

    typedef enum logic [2:0] {
        U_ARITH, U_LOGIC, U_SHIFT, U_FLAG, U_NONE
    } unit_e;

    // Packed from bit 7 down to bit 0.
    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;

    typedef struct packed {
        logic [DW-1:0] res;
        sreg_t         fl;
    } unit_out_t;

    function automatic unit_e op_unit(input alu_op_e op);
        unit_e u;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC,
            OP_INC, OP_DEC, OP_NEG:                          u = U_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_CLRM, OP_TST, OP_CLR,
            OP_COM, OP_SWAP:                                 u = U_LOGIC;
            OP_ASR, OP_LSR, OP_LSL, OP_ROL, OP_ROR:          u = U_SHIFT;
            OP_FSET, OP_FCLR:                                u = U_FLAG;
            default:                                         u = U_NONE;
        endcase
        return u;
    endfunction

    function automatic logic is_word(input alu_op_e op);
        return (op == OP_WADD) || (op == OP_WSUB);
    endfunction

    function automatic logic writes_result(input alu_op_e op);
        return !((op == OP_CMP) || (op == OP_CPC) ||
                 (op == OP_FSET) || (op == OP_FCLR));
    endfunction

    function automatic sreg_t set_nzvs(input sreg_t f, input logic [DW-1:0] r,
                                       input logic v);
        sreg_t o;
        o   = f;
        o.n = r[MSB];
        o.z = (r == '0);
        o.v = v;
        o.s = r[MSB] ^ v;
        return o;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  sreg_t         fin,
    output unit_out_t     out
);

    logic          is_sub;
    logic          use_c;
    logic          sticky_z;
    logic          keep_ch;
    logic          cin;
    logic          h;
    logic          v;
    logic [DW-1:0] x;
    logic [DW-1:0] y;
    logic [DW-1:0] r;
    logic [DW:0]   wide;

    always_comb begin
        x        = a;
        y        = b;
        is_sub   = 1'b0;
        use_c    = 1'b0;
        sticky_z = 1'b0;
        keep_ch  = 1'b0;
        case (op)
            OP_ADC:         use_c = 1'b1;
            OP_SUB, OP_CMP: is_sub = 1'b1;
            OP_SBC, OP_CPC: begin
                is_sub   = 1'b1;
                use_c    = 1'b1;
                sticky_z = 1'b1;
            end
            OP_INC: begin
                y       = DW'(1);
                keep_ch = 1'b1;
            end
            OP_DEC: begin
                y       = DW'(1);
                is_sub  = 1'b1;
                keep_ch = 1'b1;
            end
            OP_NEG: begin
                x      = '0;
                y      = a;
                is_sub = 1'b1;
            end
            default: ;
        endcase

        cin = use_c & fin.c;
        if (is_sub)
            wide = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, cin};
        else
            wide = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
        r = wide[DW-1:0];

        if (is_sub) begin
            h = (~x[HB] & y[HB]) | (y[HB] & r[HB]) | (r[HB] & ~x[HB]);
            v = (x[MSB] & ~y[MSB] & ~r[MSB]) | (~x[MSB] & y[MSB] & r[MSB]);
        end else begin
            h = (x[HB] & y[HB]) | (y[HB] & ~r[HB]) | (~r[HB] & x[HB]);
            v = (x[MSB] & y[MSB] & ~r[MSB]) | (~x[MSB] & ~y[MSB] & r[MSB]);
        end

        out.res = r;
        out.fl  = set_nzvs(fin, r, v);
        if (sticky_z)
            out.fl.z = (r == '0) & fin.z;
        if (!keep_ch) begin
            out.fl.c = wide[DW];
            out.fl.h = h;
        end
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  sreg_t         fin,
    output unit_out_t     out
);

    logic [DW-1:0] r;

    always_comb begin
        case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_CLRM: r = a & ~b;
            OP_TST:  r = a & a;
            OP_CLR:  r = a ^ a;
            OP_COM:  r = ~a;
            OP_SWAP: r = {a[HB:0], a[MSB:HB+1]};
            default: r = a;
        endcase

        out.res = r;
        if (op == OP_SWAP) begin
            out.fl = fin;
        end else begin
            out.fl = set_nzvs(fin, r, 1'b0);
            if (op == OP_COM)
                out.fl.c = 1'b1;
        end
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  sreg_t         fin,
    output unit_out_t     out
);

    logic [DW-1:0] r;
    logic          cout;

    always_comb begin
        case (op)
            OP_ASR: begin r = {a[MSB], a[MSB:1]};     cout = a[0];   end
            OP_LSR: begin r = {1'b0, a[MSB:1]};       cout = a[0];   end
            OP_LSL: begin r = {a[MSB-1:0], 1'b0};     cout = a[MSB]; end
            OP_ROL: begin r = {a[MSB-1:0], fin.c};    cout = a[MSB]; end
            OP_ROR: begin r = {fin.c, a[MSB:1]};      cout = a[0];   end
            default: begin r = a;                     cout = fin.c;  end
        endcase

        out.res  = r;
        out.fl   = set_nzvs(fin, r, r[MSB] ^ cout);
        out.fl.c = cout;
    end

endmodule

// File: rtl/alu8_word.sv
module alu8_word
    import alu8_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            sub_in,
    input  logic [WW-1:0]   pair,
    input  logic [IMMW-1:0] imm,
    input  sreg_t           fin,
    output logic            busy,
    output logic [WW-1:0]   wres,
    output sreg_t           fout
);

    logic          busy_q;
    logic          sub_q;
    logic          cy_q;
    logic [DW-1:0] hi_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] imm_ext;
    logic [DW:0]   lo_step;
    logic [DW-1:0] hi_res;
    logic          p_msb;
    logic          r_msb;
    logic          v;
    logic          c;

    assign imm_ext = {{(DW-IMMW){1'b0}}, imm};
    assign lo_step = sub_in ? ({1'b0, pair[DW-1:0]} - {1'b0, imm_ext})
                            : ({1'b0, pair[DW-1:0]} + {1'b0, imm_ext});

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sub_q  <= 1'b0;
            cy_q   <= 1'b0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else begin
            busy_q <= start;
            if (start) begin
                sub_q <= sub_in;
                hi_q  <= pair[WW-1:DW];
                lo_q  <= lo_step[DW-1:0];
                cy_q  <= lo_step[DW];
            end
        end
    end

    always_comb begin
        hi_res = sub_q ? (hi_q - {{(DW-1){1'b0}}, cy_q})
                       : (hi_q + {{(DW-1){1'b0}}, cy_q});
        wres   = {hi_res, lo_q};
        p_msb  = hi_q[MSB];
        r_msb  = hi_res[MSB];
        if (sub_q) begin
            v = p_msb & ~r_msb;
            c = r_msb & ~p_msb;
        end else begin
            v = ~p_msb & r_msb;
            c = ~r_msb & p_msb;
        end
        fout   = fin;
        fout.n = r_msb;
        fout.v = v;
        fout.s = r_msb ^ v;
        fout.z = (wres == '0);
        fout.c = c;
    end

    assign busy = busy_q;

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [OPW-1:0]  op_code,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    input  logic [WW-1:0]   pair_in,
    output logic            res_valid,
    output logic            res_write,
    output logic [WW-1:0]   res_data,
    output logic [FLW-1:0]  flags,
    output logic            busy
);

    alu_op_e       op;
    logic          accept;
    logic          word_busy;
    sreg_t         flags_q;
    unit_out_t     arith_o;
    unit_out_t     logic_o;
    unit_out_t     shift_o;
    logic [WW-1:0] word_res;
    sreg_t         word_fl;
    logic [FLW-1:0] fl_vec;
    logic [FLW-1:0] fl_bitop;
    logic [DW-1:0] nxt_res;
    sreg_t         nxt_fl;
    logic          res_valid_q;
    logic          res_write_q;
    logic [WW-1:0] res_q;

    assign op     = alu_op_e'(op_code);
    assign accept = op_valid & ~word_busy;
    assign fl_vec = flags_q;

    alu8_arith u_arith (
        .op  (op),
        .a   (opa),
        .b   (opb),
        .fin (flags_q),
        .out (arith_o)
    );

    alu8_logic u_logic (
        .op  (op),
        .a   (opa),
        .b   (opb),
        .fin (flags_q),
        .out (logic_o)
    );

    alu8_shift u_shift (
        .op  (op),
        .a   (opa),
        .fin (flags_q),
        .out (shift_o)
    );

    alu8_word u_word (
        .clk    (clk),
        .rst    (rst),
        .start  (accept & is_word(op)),
        .sub_in (op == OP_WSUB),
        .pair   (pair_in),
        .imm    (opb[IMMW-1:0]),
        .fin    (flags_q),
        .busy   (word_busy),
        .wres   (word_res),
        .fout   (word_fl)
    );

    // One select per status bit for the flag set and clear operations.
    for (genvar gi = 0; gi < FLW; gi++) begin : g_flagbit
        assign fl_bitop[gi] = (opb[FIDXW-1:0] == FIDXW'(gi)) ? (op == OP_FSET)
                                                              : fl_vec[gi];
    end

    always_comb begin
        case (op_unit(op))
            U_ARITH: begin nxt_res = arith_o.res; nxt_fl = arith_o.fl; end
            U_LOGIC: begin nxt_res = logic_o.res; nxt_fl = logic_o.fl; end
            U_SHIFT: begin nxt_res = shift_o.res; nxt_fl = shift_o.fl; end
            U_FLAG:  begin nxt_res = '0;          nxt_fl = sreg_t'(fl_bitop); end
            default: begin nxt_res = '0;          nxt_fl = flags_q; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q     <= '0;
            res_valid_q <= 1'b0;
            res_write_q <= 1'b0;
            res_q       <= '0;
        end else begin
            res_valid_q <= 1'b0;
            res_write_q <= 1'b0;
            if (word_busy) begin
                res_valid_q <= 1'b1;
                res_write_q <= 1'b1;
                res_q       <= word_res;
                flags_q     <= word_fl;
            end else if (accept && !is_word(op)) begin
                res_valid_q <= 1'b1;
                res_write_q <= writes_result(op);
                flags_q     <= nxt_fl;
                if (writes_result(op))
                    res_q <= {{(WW-DW){1'b0}}, nxt_res};
            end
        end
    end

    assign res_valid = res_valid_q;
    assign res_write = res_write_q;
    assign res_data  = res_q;
    assign flags     = flags_q;
    assign busy      = word_busy;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           op_valid,
    input logic [OPW-1:0] op_code,
    input logic           busy,
    input logic           res_valid,
    input logic           res_write,
    input logic [FLW-1:0] flags
);

    alu_op_e opc;
    logic    acc;
    logic    acc_logic;

    assign opc       = alu_op_e'(op_code);
    assign acc       = op_valid & ~busy;
    assign acc_logic = acc && (opc == OP_AND || opc == OP_OR || opc == OP_XOR ||
                               opc == OP_CLRM || opc == OP_TST || opc == OP_CLR ||
                               opc == OP_COM);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_write && !busy && flags == '0));

    assert_sticky_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (acc && (opc == OP_SBC || opc == OP_CPC) && !flags[1]) |=> !flags[1]);

    assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (rst)
        (acc && (opc == OP_CMP || opc == OP_CPC)) |=> (res_valid && !res_write));

    assert_logic_v_zero_R5: assert property (@(posedge clk) disable iff (rst)
        acc_logic |=> (!flags[3] && (flags[4] == flags[2])));

    assert_swap_keeps_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && opc == OP_SWAP) |=> $stable(flags));

    assert_word_enters_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (acc && (opc == OP_WADD || opc == OP_WSUB)) |=> (busy && !res_valid));

    assert_word_finishes_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy && res_valid && res_write));

    assert_flag_op_no_write_R11: assert property (@(posedge clk) disable iff (rst)
        (acc && (opc == OP_FSET || opc == OP_FCLR)) |=> (res_valid && !res_write));

    assert_it_only_by_flag_ops_R12: assert property (@(posedge clk) disable iff (rst)
        !(acc && (opc == OP_FSET || opc == OP_FCLR)) |=> $stable(flags[7:6]));

    assert_single_cycle_valid_R13: assert property (@(posedge clk) disable iff (rst)
        (acc && !(opc == OP_WADD || opc == OP_WSUB)) |=> (res_valid && !busy));

    assert_valid_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !busy) |=> !res_valid);

endmodule

bind alu8_core alu8_core_chk u_chk (.*);

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
    import alu8_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [7:0]  opa = '0;
    logic [7:0]  opb = '0;
    logic [15:0] pair_in = '0;
    logic        res_valid;
    logic        res_write;
    logic [15:0] res_data;
    logic [7:0]  flags;
    logic        busy;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] mflags = '0;

    always #4 clk = ~clk;

    alu8_core u_alu8_core (
        .clk, .rst, .op_valid, .op_code, .opa, .opb, .pair_in,
        .res_valid, .res_write, .res_data, .flags, .busy
    );

    function automatic string req_tag(input alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB:             return "R2";
            OP_SBC, OP_CPC:                     return "R3";
            OP_CMP:                             return "R4";
            OP_AND, OP_OR, OP_XOR, OP_CLRM,
            OP_TST, OP_CLR, OP_INC, OP_DEC:     return "R5";
            OP_COM, OP_NEG:                     return "R6";
            OP_SWAP:                            return "R7";
            OP_ASR, OP_LSR, OP_LSL:             return "R8";
            OP_ROL, OP_ROR:                     return "R9";
            OP_WADD, OP_WSUB:                   return "R10";
            default:                            return "R11";
        endcase
    endfunction

    // Bit positions: C0 Z1 N2 V3 S4 H5 T6 I7 (R2).
    function automatic void model(input alu_op_e op, input logic [7:0] a,
                                  input logic [7:0] b, input logic [15:0] p,
                                  input logic [7:0] fi, output logic wr,
                                  output logic [15:0] r, output logic [7:0] fo);
        int s, hs, sv, ci, x, y, sx;
        logic [7:0] q;
        fo = fi; wr = 1'b1; r = '0; q = '0;
        ci = (op == OP_ADC || op == OP_SBC || op == OP_CPC) ? int'(fi[0]) : 0;
        case (op)
            OP_ADD, OP_ADC: begin
                s  = int'(a) + int'(b) + ci;
                hs = int'(a & 8'h0F) + int'(b & 8'h0F) + ci;
                sv = int'($signed(a)) + int'($signed(b)) + ci;
                q  = s[7:0];
                fo[0] = (s > 255); fo[5] = (hs > 15);
                fo[3] = (sv > 127 || sv < -128);
                fo[2] = q[7]; fo[1] = (q == 0);
            end
            OP_SUB, OP_SBC, OP_CMP, OP_CPC, OP_NEG: begin
                x  = (op == OP_NEG) ? 0 : int'(a);
                y  = (op == OP_NEG) ? int'(a) : int'(b);
                sx = (op == OP_NEG) ? 0 : int'($signed(a));
                s  = x - y - ci;
                hs = (x % 16) - (y % 16) - ci;
                sv = sx - int'($signed(y[7:0])) - ci;
                q  = s[7:0];
                fo[0] = (s < 0); fo[5] = (hs < 0);
                fo[3] = (sv > 127 || sv < -128);
                fo[2] = q[7];
                fo[1] = (op == OP_SBC || op == OP_CPC) ? ((q == 0) && fi[1]) : (q == 0);
                wr = !(op == OP_CMP || op == OP_CPC);
            end
            OP_INC, OP_DEC: begin
                sv = int'($signed(a)) + ((op == OP_INC) ? 1 : -1);
                s  = int'(a) + ((op == OP_INC) ? 1 : 255);
                q  = s[7:0];
                fo[3] = (sv > 127 || sv < -128);
                fo[2] = q[7]; fo[1] = (q == 0);
            end
            OP_AND, OP_OR, OP_XOR, OP_CLRM, OP_TST, OP_CLR, OP_COM: begin
                case (op)
                    OP_AND:  q = a & b;
                    OP_OR:   q = a | b;
                    OP_XOR:  q = a ^ b;
                    OP_CLRM: q = a & (8'hFF - b);
                    OP_TST:  q = a;
                    OP_CLR:  q = 8'h00;
                    default: q = 8'hFF - a;
                endcase
                fo[3] = 1'b0; fo[2] = q[7]; fo[1] = (q == 0);
                if (op == OP_COM) fo[0] = 1'b1;
            end
            OP_SWAP: begin
                s = (int'(a) % 16) * 16 + int'(a) / 16;
                q = s[7:0];
            end
            OP_ASR, OP_LSR, OP_LSL, OP_ROL, OP_ROR: begin
                case (op)
                    OP_ASR: begin s = int'(a) / 2 + ((a >= 128) ? 128 : 0); fo[0] = a[0]; end
                    OP_LSR: begin s = int'(a) / 2;                          fo[0] = a[0]; end
                    OP_LSL: begin s = int'(a) * 2;                          fo[0] = (a >= 128); end
                    OP_ROL: begin s = int'(a) * 2 + int'(fi[0]);            fo[0] = (a >= 128); end
                    default: begin s = int'(a) / 2 + int'(fi[0]) * 128;     fo[0] = a[0]; end
                endcase
                q = s[7:0];
                fo[2] = q[7]; fo[1] = (q == 0); fo[3] = q[7] ^ fo[0];
            end
            OP_WADD, OP_WSUB: begin
                y  = int'(b) % 64;
                s  = (op == OP_WADD) ? int'(p) + y : int'(p) - y;
                sv = (op == OP_WADD) ? int'($signed(p)) + y : int'($signed(p)) - y;
                r  = s[15:0];
                fo[0] = (op == OP_WADD) ? (s > 65535) : (s < 0);
                fo[3] = (sv > 32767 || sv < -32768);
                fo[2] = r[15]; fo[1] = (r == 0);
                fo[4] = fo[2] ^ fo[3];
            end
            OP_FSET: begin fo[b[2:0]] = 1'b1; wr = 1'b0; end
            default: begin fo[b[2:0]] = 1'b0; wr = 1'b0; end
        endcase
        if (!(op == OP_WADD || op == OP_WSUB || op == OP_FSET || op == OP_FCLR
              || op == OP_SWAP)) begin
            fo[4] = fo[2] ^ fo[3];
            r = {8'h00, q};
        end else if (op == OP_SWAP) begin
            r = {8'h00, q};
        end
    endfunction

    task automatic check(input bit ok, input string tag, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s", tag, what);
        end
    endtask

    task automatic run_op(input alu_op_e op, input logic [7:0] a,
                          input logic [7:0] b, input logic [15:0] p);
        logic        ewr;
        logic [15:0] er;
        logic [7:0]  ef;
        model(op, a, b, p, mflags, ewr, er, ef);
        op_valid = 1'b1; op_code = op; opa = a; opb = b; pair_in = p;
        @(negedge clk);
        if (op == OP_WADD || op == OP_WSUB) begin
            op_valid = 1'b0;
            check(busy && !res_valid, "R10",
                  $sformatf("busy phase: busy=%b valid=%b, expected 1 0", busy, res_valid));
            @(negedge clk);
        end
        op_valid = 1'b0;
        check(res_valid && (res_write == ewr) && (!ewr || res_data == er) && (flags == ef),
              req_tag(op),
              $sformatf("%s a=%h b=%h p=%h: got v=%b w=%b r=%h f=%b, expected v=1 w=%b r=%h f=%b",
                        op.name(), a, b, p, res_valid, res_write, res_data, flags, ewr, er, ef));
        mflags = ef;
    endtask

    localparam logic [7:0] BV [8] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFE, 8'hFF};
    localparam alu_op_e SOPS [22] = '{
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC, OP_INC, OP_DEC, OP_NEG,
        OP_AND, OP_OR, OP_XOR, OP_CLRM, OP_TST, OP_CLR, OP_COM, OP_SWAP,
        OP_ASR, OP_LSR, OP_LSL, OP_ROL, OP_ROR};

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        check(!res_valid && !res_write && !busy && flags == 8'h00, "R1",
              $sformatf("reset: v=%b w=%b busy=%b f=%b, expected 0 0 0 00000000",
                        res_valid, res_write, busy, flags));

        // R11 and R12: set and clear every status bit, I and T included.
        for (int k = 0; k < 8; k++) run_op(OP_FSET, 8'h00, 8'(k), 16'h0000);
        for (int k = 0; k < 8; k++) run_op(OP_FCLR, 8'h00, 8'(k), 16'h0000);
        run_op(OP_FSET, 8'h00, 8'd6, 16'h0000);
        run_op(OP_FSET, 8'h00, 8'd7, 16'h0000);

        // R2 to R9: sweep every single-cycle operation, flags chained.
        foreach (SOPS[oi]) begin
            for (int a = 0; a < 256; a++) begin
                for (int bi = 0; bi < 8; bi++)
                    run_op(SOPS[oi], 8'(a), BV[bi], 16'h0000);
            end
        end

        // R3: sticky zero, both directions, directed.
        run_op(OP_FSET, 8'h00, 8'd1, 16'h0000);
        run_op(OP_FCLR, 8'h00, 8'd0, 16'h0000);
        run_op(OP_CPC,  8'h42, 8'h42, 16'h0000);
        check(flags[1] == 1'b1, "R3", $sformatf("zero result keeps Z: got %b, expected 1", flags[1]));
        run_op(OP_FCLR, 8'h00, 8'd1, 16'h0000);
        run_op(OP_SBC,  8'h42, 8'h42, 16'h0000);
        check(flags[1] == 1'b0, "R3", $sformatf("cleared Z stays clear: got %b, expected 0", flags[1]));

        // R10: word sweep over pair values and all immediates.
        for (int pi = 0; pi < 64; pi++) begin
            logic [15:0] pv;
            pv = (pi == 1) ? 16'hFFFF : (pi == 2) ? 16'h7FC0 : (pi == 3) ? 16'h8000 :
                 16'(pi * 1041);
            for (int im = 0; im < 64; im++) begin
                run_op(OP_WADD, 8'(im), 8'(im), pv);
                run_op(OP_WSUB, 8'(im), 8'(im) | 8'hC0, pv);
            end
        end

        // R10: an operation offered during busy is ignored.
        begin
            logic        ewr;
            logic [15:0] er;
            logic [7:0]  ef;
            model(OP_WADD, 8'h00, 8'h3F, 16'h00F0, mflags, ewr, er, ef);
            op_valid = 1'b1; op_code = OP_WADD; opb = 8'h3F; pair_in = 16'h00F0;
            @(negedge clk);
            op_code = OP_CLR; opa = 8'h55; opb = 8'h00;
            @(negedge clk);
            op_valid = 1'b0;
            check(res_valid && res_data == er && flags == ef, "R10",
                  $sformatf("ignored op: got r=%h f=%b, expected r=%h f=%b",
                            res_data, flags, er, ef));
            mflags = ef;
            @(negedge clk);
            check(!res_valid && !busy, "R10",
                  $sformatf("after ignored op: valid=%b busy=%b, expected 0 0", res_valid, busy));
        end

        // R13: one-cycle pulse and write qualifier.
        run_op(OP_ADD, 8'h01, 8'h02, 16'h0000);
        @(negedge clk);
        check(!res_valid, "R13", $sformatf("valid pulse: got %b, expected 0", res_valid));
        run_op(OP_CMP, 8'h05, 8'h05, 16'h0000);
        check(!res_write, "R13", $sformatf("compare write: got %b, expected 0", res_write));

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule